// File: doc/BRIEF.md
# Vectored Interrupt and Trap Controller

This block sits next to a small processor core and decides when control moves to an interrupt or trap handler, and to which address. Each interrupt source drives a request line whose rising edge latches a pending bit. A mask register selects which pending sources may cause vectored service. When the core signals that it has reached an interruptible point and no service is already running, the highest-priority enabled pending source is taken. The block pulses a take request with the handler address, raises an acknowledge output and shows a 4-bit code naming the source until the core signals return.

Two traps, a user trap and a debug trap, take control at once, whatever the core's interruptible state. A trap that arrives while a trap is active is ignored. The user trap drives the acknowledge and code outputs. The debug trap leaves them showing the state from before the trap. Pending bits clear in one of four ways: a write of 1 over the register bus (external and timer sources only), the return strobe for the source being served, a peripheral access strobe that clears at once (parallel-port sources), or a peripheral access strobe that clears one cycle later (serial-port sources).

Top module: `irq_trap_ctrl`

## Requirements
- R1: After reset the mask and status registers read 0, and take_o, ack_o and code_o are 0.
- R2: A rising edge on irq_i[i] sets status bit i on the next clock whatever the mask. A request held high does not set the bit again once it has been cleared.
- R3: A vectored service starts only at a clock where at_point_i is 1. take_o then pulses for one cycle with vec_o = 0x10 + 2*i.
- R4: When several enabled sources are pending, the lowest index is served first.
- R5: Mask bit 1 enables a source and 0 blocks it. Source 7 (software) is always enabled. A pending source that is later unmasked is served.
- R6: No vectored service starts while a service or a trap is active.
- R7: During the vectored service of source i, ack_o is 1 and code_o = i+1. ret_i ends the service and clears status bit i only. Other pending bits stay set.
- R8: A bus write to address 1 (status) clears the status bits 0 to 2 where the write data is 1. Other status bits are unaffected.
- R9: clr_i[5] and clr_i[6] clear their status bit on the next clock. clr_i[3] and clr_i[4] clear their bit one clock later.
- R10: trap_usr_i or trap_dbg_i is taken without at_point_i, with vec_o 0x46 (user) or 0x03 (debug). The debug trap wins over the user trap, and either wins over a vectored source.
- R11: While a trap is active, further traps are ignored until ret_i.
- R12: A user trap drives ack_o=1 and code_o=0xF. A debug trap leaves ack_o and code_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Per-source request lines, edge detected |
| clr_i | input | 8 | Peripheral data-access clear strobes |
| trap_usr_i | input | 1 | User trap request |
| trap_dbg_i | input | 1 | Debug trap request |
| at_point_i | input | 1 | Core at an interruptible point |
| ret_i | input | 1 | Return from service |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 = mask, 1 = status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| take_o | output | 1 | One-cycle transfer request |
| vec_o | output | 8 | Handler address |
| ack_o | output | 1 | Service in progress |
| code_o | output | 4 | Source code of the current service |

## Verification
Assertions check on every cycle that a vectored take only follows an interruptible point and never lands inside a running service, that the acknowledge holds until a return, that the code is nonzero exactly when the acknowledge is high, that a debug trap leaves both unchanged, and that a second trap is ignored. Priority order, the different clear timings, write-1-to-clear limits, late unmasking and edge-only latching depend on sequences of events, and only the bench scenarios and the random status model show them.

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl #(
  parameter int NSRC = 8,
  parameter int VW = 8,
  parameter logic [VW-1:0] VBASE = 8'h10,
  parameter logic [VW-1:0] UTRAP_VEC = 8'h46,
  parameter logic [VW-1:0] DTRAP_VEC = 8'h03,
  parameter logic [NSRC-1:0] W1C_MASK = 8'h07,
  parameter logic [NSRC-1:0] LATE_MASK = 8'h18,
  parameter logic [NSRC-1:0] SW_MASK = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            trap_usr_i,
  input  logic            trap_dbg_i,
  input  logic            at_point_i,
  input  logic            ret_i,
  input  logic            bus_wr_i,
  input  logic            bus_addr_i,
  input  logic [NSRC-1:0] bus_wdata_i,
  output logic [NSRC-1:0] bus_rdata_o,
  output logic            take_o,
  output logic [VW-1:0]   vec_o,
  output logic            ack_o,
  output logic [3:0]      code_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] mask_q, stat_q, irq_q, late_q;
  logic            in_svc, trap_act, trap_usr;
  logic [IW-1:0]   cur, win;
  logic [NSRC-1:0] pend, clr, ret_clr, rise;

  assign rise = irq_i & ~irq_q;
  assign pend = stat_q & (mask_q | SW_MASK);
  assign ret_clr = (ret_i && in_svc && !trap_act) ? (NSRC'(1) << cur) : '0;
  assign clr = ((bus_wr_i && bus_addr_i) ? (bus_wdata_i & W1C_MASK) : '0)
             | (clr_i & ~LATE_MASK) | late_q | ret_clr;
  assign bus_rdata_o = bus_addr_i ? stat_q : mask_q;
  assign ack_o = in_svc | (trap_act & trap_usr);
  assign code_o = (trap_act && trap_usr) ? 4'hF : (in_svc ? 4'(cur) + 4'd1 : 4'd0);

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q <= '0;
      late_q <= '0;
    end else begin
      irq_q <= irq_i;
      late_q <= clr_i & LATE_MASK;
      stat_q <= (stat_q & ~clr) | rise;
      if (bus_wr_i && !bus_addr_i) mask_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_svc <= 1'b0;
      trap_act <= 1'b0;
      trap_usr <= 1'b0;
      cur <= '0;
      take_o <= 1'b0;
      vec_o <= '0;
    end else begin
      take_o <= 1'b0;
      if (ret_i) begin
        if (trap_act) trap_act <= 1'b0;
        else in_svc <= 1'b0;
      end
      if (!trap_act && (trap_dbg_i || trap_usr_i)) begin
        trap_act <= 1'b1;
        trap_usr <= !trap_dbg_i;
        take_o <= 1'b1;
        vec_o <= trap_dbg_i ? DTRAP_VEC : UTRAP_VEC;
      end else if (at_point_i && !in_svc && !trap_act && |pend) begin
        in_svc <= 1'b1;
        cur <= win;
        take_o <= 1'b1;
        vec_o <= VBASE + VW'({win, 1'b0});
      end
    end
  end
endmodule

module irq_trap_ctrl_chk #(
  parameter int VW = 8,
  parameter logic [VW-1:0] UTRAP_VEC = 8'h46,
  parameter logic [VW-1:0] DTRAP_VEC = 8'h03
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_o,
  input logic [VW-1:0] vec_o,
  input logic          ack_o,
  input logic [3:0]    code_o,
  input logic          at_point_i,
  input logic          ret_i,
  input logic          trap_usr_i,
  input logic          trap_dbg_i,
  input logic          trap_act
);
  logic vect_take;
  assign vect_take = take_o && vec_o != UTRAP_VEC && vec_o != DTRAP_VEC;

  assert_take_at_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vect_take |-> $past(at_point_i));
  assert_no_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vect_take |-> !$past(ack_o) || $past(ret_i));
  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ret_i) |=> ack_o);
  assert_code_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != 4'd0) == ack_o);
  assert_dbg_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == DTRAP_VEC && !$past(ret_i)) |-> ($stable(ack_o) && $stable(code_o)));
  assert_trap_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_act && (trap_usr_i || trap_dbg_i) && !ret_i) |=> !take_o);
endmodule

bind irq_trap_ctrl irq_trap_ctrl_chk #(.VW(VW), .UTRAP_VEC(UTRAP_VEC), .DTRAP_VEC(DTRAP_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o),
  .code_o(code_o), .at_point_i(at_point_i), .ret_i(ret_i),
  .trap_usr_i(trap_usr_i), .trap_dbg_i(trap_dbg_i), .trap_act(trap_act));

// File: tb/irq_trap_ctrl_tb_top.sv
module irq_trap_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq = 0, clr = 0, wdata = 0, rdata, vec;
  logic tu = 0, td = 0, atp = 0, ret = 0, wr = 0, addr = 0;
  logic take, ack;
  logic [3:0] code;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  irq_trap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .clr_i(clr), .trap_usr_i(tu), .trap_dbg_i(td),
    .at_point_i(atp), .ret_i(ret), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .take_o(take), .vec_o(vec), .ack_o(ack), .code_o(code));

  function automatic logic [7:0] exp_vec(int i);
    return 8'h10 + 8'(2 * i);
  endfunction

  function automatic logic [7:0] exp_stat(logic [7:0] st, logic [7:0] prev, logic [7:0] now,
                                          logic [7:0] w1c);
    return (st & ~(w1c & 8'h07)) | (now & ~prev);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_stat(string req, logic [7:0] exp);
    addr = 1; #1; chk(req, rdata, exp);
  endtask

  task automatic wreg(logic a, logic [7:0] d);
    wr = 1; addr = a; wdata = d; step(); wr = 0;
  endtask

  task automatic pulse_irq(logic [7:0] b);
    irq = b; step(); irq = 0; step();
  endtask

  task automatic go_point;
    atp = 1; step(); atp = 0;
  endtask

  task automatic do_ret;
    ret = 1; step(); ret = 0;
  endtask

  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] st, prev, r, w;
    step(3); rst_n = 1; step();
    // R1
    addr = 0; #1; chk("R1 mask", rdata, 0);
    rd_stat("R1 status", 0);
    chk("R1 outs", {take, ack, code}, 0);
    // R2, R5 masked still latched
    pulse_irq(8'h04);
    rd_stat("R2 status set", 8'h04);
    go_point; chk("R5 masked no take", take, 0);
    wreg(0, 8'h07);
    go_point;
    chk("R3 take", take, 1); chk("R3 vec", vec, exp_vec(2));
    chk("R7 ack", ack, 1); chk("R7 code", code, 3);
    step(); chk("R3 one pulse", take, 0);
    // R6
    pulse_irq(8'h01);
    go_point; chk("R6 no nest", take, 0);
    // R7 return clears only served bit
    do_ret; chk("R7 ack drop", ack, 0); rd_stat("R7 status", 8'h01);
    go_point; chk("R7 next vec", vec, exp_vec(0)); chk("R7 code0", code, 1);
    do_ret;
    // R4
    wreg(0, 8'hFF);
    pulse_irq(8'h22);
    go_point; chk("R4 first", vec, exp_vec(1));
    do_ret; go_point; chk("R4 second", vec, exp_vec(5));
    do_ret; rd_stat("R4 empty", 0);
    // R8
    pulse_irq(8'h09);
    wreg(1, 8'hFF); rd_stat("R8 w1c", 8'h08);
    // R9
    clr = 8'h08; step(); clr = 0;
    rd_stat("R9 late still set", 8'h08);
    step(); rd_stat("R9 late cleared", 8'h00);
    pulse_irq(8'h40);
    clr = 8'h40; step(); clr = 0;
    rd_stat("R9 direct cleared", 8'h00);
    // R2 held level
    irq = 8'h10; step(2);
    clr = 8'h10; step(); clr = 0; step(3);
    rd_stat("R2 held no reset", 8'h00);
    irq = 0; step();
    // R5 software source unmaskable
    wreg(0, 8'h00);
    pulse_irq(8'h80);
    go_point; chk("R5 sw take", take, 1); chk("R5 sw vec", vec, exp_vec(7));
    chk("R7 sw code", code, 8);
    do_ret;
    // R10, R12, R11
    tu = 1; step(); tu = 0;
    chk("R10 user take", take, 1); chk("R10 user vec", vec, 8'h46);
    chk("R12 user ack", ack, 1); chk("R12 user code", code, 4'hF);
    td = 1; step(); td = 0; chk("R11 ignored", take, 0);
    do_ret; chk("R12 ack drop", ack, 0);
    wreg(0, 8'h01);
    pulse_irq(8'h01); go_point; chk("R12 svc code", code, 1);
    td = 1; step(); td = 0;
    chk("R10 dbg vec", vec, 8'h03); chk("R12 dbg ack", ack, 1); chk("R12 dbg code", code, 1);
    do_ret; chk("R12 after dbg ret", ack, 1);
    do_ret; chk("R7 final drop", ack, 0);
    pulse_irq(8'h01);
    tu = 1; td = 1; atp = 1; step(); tu = 0; td = 0; atp = 0;
    chk("R10 dbg wins", vec, 8'h03);
    do_ret;
    go_point; chk("R10 vect after", vec, exp_vec(0)); do_ret;
    // random status model
    void'($urandom(32'd1234));
    wreg(0, 8'h00);
    st = 0; prev = 0;
    for (int k = 0; k < 300; k++) begin
      r = 8'($urandom);
      w = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      irq = r;
      wr = (w != 0); addr = 1; wdata = w;
      step(); wr = 0;
      st = exp_stat(st, prev, r, w); prev = r;
      rd_stat("R2 R8 random", st);
    end
    irq = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule